// File: doc/BRIEF.md
# Effective Address Sequencer

This unit works out the operand address of an 8-bit processor instruction. A one-cycle start pulse hands it an addressing-mode code, the address of the instruction's first operand byte, and the X and Y index values. It then fetches the bytes it needs, one at a time, over a simple synchronous read port. When it has them, it presents the 16-bit effective address together with a one-cycle done pulse.

The unit reproduces the wrap behaviour that software written for this processor family relies on. Zero-page indexing stays inside page zero. Zero-page pointers wrap from 0xFF back to 0x00. The indirect jump pointer never carries into the next page. Multi-byte values are little-endian, so the low byte sits at the lower address.

Mode codes (4 bits): 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 pre-indexed pointer (X), 8 post-indexed pointer (Y), 9 indirect jump pointer. Codes 10 to 15 are unsupported.

Top module: `ea_sequencer`

## Requirements
- R1: For mode 0, done_o is high in the cycle after the accepted start, ea_o equals the operand location, and no read is issued.
- R2: For modes 1, 2 and 3, one byte is read at the operand location. ea_o has a high byte of 0x00 and a low byte equal to that byte plus 0, X or Y respectively, modulo 256.
- R3: For modes 4, 5 and 6, the low byte is read at the operand location and the high byte at the operand location + 1 (modulo 65536). ea_o is {high, low} plus 0, X or Y respectively, modulo 65536.
- R4: For mode 7, the pointer is the operand byte + X modulo 256. ea_o takes its low byte from address {0x00, pointer} and its high byte from {0x00, pointer + 1 modulo 256}.
- R5: For mode 8, with P the operand byte, the low byte is read at {0x00, P} and the high byte at {0x00, P + 1 modulo 256}. ea_o is {high, low} + Y modulo 65536.
- R6: For mode 9, the 16-bit pointer is read little-endian from the operand location. The target low byte is read at the pointer. The target high byte is read at {pointer[15:8], pointer[7:0] + 1 modulo 256}, so a pointer ending in 0xFF takes its high byte from the start of the same page.
- R7: Each read holds mem_rd_o high for exactly one cycle. The byte arrives on mem_data_i in the following cycle. Reads are issued back to back every two cycles, so an operation with n reads raises done_o 2n+1 cycles after the cycle in which start_i was sampled.
- R8: Start pulses and changes on mode_i, oploc_i, x_i and y_i while busy_o is high have no effect on the running operation or its result.
- R9: A mode code from 10 to 15 gives done_o in the cycle after the start, with err_o = 1, ea_o = 0 and no read. Every supported mode finishes with err_o = 0.
- R10: busy_o is high from the cycle after an accepted start of a reading mode until the done cycle, and it is low in the done cycle. After reset, busy_o, done_o, mem_rd_o, err_o and ea_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; accepted only while idle |
| mode_i | input | 4 | Addressing-mode code |
| oploc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| mem_addr_o | output | 16 | Read address |
| mem_rd_o | output | 1 | Read strobe, one cycle per byte |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 16 | Effective address, held until the next completion |
| err_o | output | 1 | Unsupported mode flag, valid with done_o |

## Verification
The hardest cases to reach are the page-wrap corners. Each needs a fetched pointer byte of exactly 0xFF, and for the indirect jump the memory must also hold distinct bytes at the start of the pointer's own page and at the start of the next page, so that the wrong choice gives a visibly wrong address. The bench's memory model plants these bytes, and the stimulus points operands at them. A second hard case is a start pulse, with a new mode and new operands, that arrives mid-operation. The driver injects one in the cycle after a start, while the unit is still fetching, and the scoreboard then checks that the original result, its read count and its latency are unchanged.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

    localparam int STEP_W = 2;

    typedef enum logic [3:0] {
        M_IMM  = 4'd0,
        M_ZP   = 4'd1,
        M_ZPX  = 4'd2,
        M_ZPY  = 4'd3,
        M_ABS  = 4'd4,
        M_ABSX = 4'd5,
        M_ABSY = 4'd6,
        M_INDX = 4'd7,
        M_INDY = 4'd8,
        M_JIND = 4'd9
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_CAPT  = 2'd2
    } state_e;

    function automatic logic mode_known(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

    // index of the final byte fetch for each reading mode
    function automatic logic [STEP_W-1:0] last_step(input mode_e m);
        case (m)
            M_ZP, M_ZPX, M_ZPY:    return 2'd0;
            M_ABS, M_ABSX, M_ABSY: return 2'd1;
            M_INDX, M_INDY:        return 2'd2;
            M_JIND:                return 2'd3;
            default:               return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ea_step_addr.sv
module ea_step_addr
    import ea_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  mode_e                   mode,
    input  logic [STEP_W-1:0]       step,
    input  logic [ADDR_W-1:0]       loc,
    input  logic [DATA_W-1:0]       xr,
    input  logic [DATA_W-1:0]       b0,
    input  logic [DATA_W-1:0]       b1,
    output logic [ADDR_W-1:0]       addr
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] zp_ptr;
    logic [DATA_W-1:0] zp_ptr_inc;
    logic              wide_operand;

    always_comb begin
        zp_ptr       = (mode == M_INDX) ? DATA_W'(b0 + xr) : b0;
        zp_ptr_inc   = DATA_W'(zp_ptr + 1'b1);
        wide_operand = (mode == M_ABS) || (mode == M_ABSX) ||
                       (mode == M_ABSY) || (mode == M_JIND);
        case (step)
            2'd0: addr = loc;
            2'd1: addr = wide_operand ? ADDR_W'(loc + 1'b1)
                                      : {{PAGE_W{1'b0}}, zp_ptr};
            2'd2: addr = (mode == M_JIND) ? {b1, b0}
                                          : {{PAGE_W{1'b0}}, zp_ptr_inc};
            default: addr = {b1, DATA_W'(b0 + 1'b1)};
        endcase
    end

endmodule

// File: rtl/ea_result.sv
module ea_result
    import ea_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  mode_e               mode,
    input  logic [DATA_W-1:0]   xr,
    input  logic [DATA_W-1:0]   yr,
    input  logic [DATA_W-1:0]   b0,
    input  logic [DATA_W-1:0]   b1,
    input  logic [DATA_W-1:0]   b2,
    input  logic [DATA_W-1:0]   b3,
    output logic [ADDR_W-1:0]   ea
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] x_wide;
    logic [ADDR_W-1:0] y_wide;

    always_comb begin
        x_wide = {{PAGE_W{1'b0}}, xr};
        y_wide = {{PAGE_W{1'b0}}, yr};
        case (mode)
            M_ZP:    ea = {{PAGE_W{1'b0}}, b0};
            M_ZPX:   ea = {{PAGE_W{1'b0}}, DATA_W'(b0 + xr)};
            M_ZPY:   ea = {{PAGE_W{1'b0}}, DATA_W'(b0 + yr)};
            M_ABS:   ea = {b1, b0};
            M_ABSX:  ea = ADDR_W'({b1, b0} + x_wide);
            M_ABSY:  ea = ADDR_W'({b1, b0} + y_wide);
            M_INDX:  ea = {b2, b1};
            M_INDY:  ea = ADDR_W'({b2, b1} + y_wide);
            M_JIND:  ea = {b3, b2};
            default: ea = '0;
        endcase
    end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] oploc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic              err_o
);
    localparam int NBYTES = 1 << STEP_W;

    typedef struct packed {
        state_e                         st;
        mode_e                          mode;
        logic [ADDR_W-1:0]              loc;
        logic [DATA_W-1:0]              xr;
        logic [DATA_W-1:0]              yr;
        logic [STEP_W-1:0]              step;
        logic [NBYTES-1:0][DATA_W-1:0]  bytes;
        logic                           done;
        logic                           err;
        logic [ADDR_W-1:0]              ea;
    } seq_t;

    seq_t r_d, r_q;

    logic [NBYTES-1:0][DATA_W-1:0] cur_bytes;
    logic [ADDR_W-1:0]             rd_addr;
    logic [ADDR_W-1:0]             final_ea;

    // bytes as they stand including the one arriving this cycle
    always_comb begin
        cur_bytes            = r_q.bytes;
        cur_bytes[r_q.step]  = mem_data_i;
    end

    ea_step_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step_addr (
        .mode (r_q.mode),
        .step (r_q.step),
        .loc  (r_q.loc),
        .xr   (r_q.xr),
        .b0   (r_q.bytes[0]),
        .b1   (r_q.bytes[1]),
        .addr (rd_addr)
    );

    ea_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_result (
        .mode (r_q.mode),
        .xr   (r_q.xr),
        .yr   (r_q.yr),
        .b0   (cur_bytes[0]),
        .b1   (cur_bytes[1]),
        .b2   (cur_bytes[2]),
        .b3   (cur_bytes[3]),
        .ea   (final_ea)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.mode = mode_e'(mode_i);
                    r_d.loc  = oploc_i;
                    r_d.xr   = x_i;
                    r_d.yr   = y_i;
                    r_d.step = '0;
                    if (!mode_known(mode_i)) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                        r_d.ea   = '0;
                    end else if (mode_i == 4'(M_IMM)) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b0;
                        r_d.ea   = oploc_i;
                    end else begin
                        r_d.st   = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                r_d.st = S_CAPT;
            end
            S_CAPT: begin
                r_d.bytes = cur_bytes;
                if (r_q.step == last_step(r_q.mode)) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b0;
                    r_d.ea   = final_ea;
                end else begin
                    r_d.step = r_q.step + 1'b1;
                    r_d.st   = S_ISSUE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr_o = rd_addr;
    assign mem_rd_o   = (r_q.st == S_ISSUE);
    assign busy_o     = (r_q.st != S_IDLE);
    assign done_o     = r_q.done;
    assign ea_o       = r_q.ea;
    assign err_o      = r_q.err;

    AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mode_i == 4'd0) |=>
        (done_o && !mem_rd_o && !err_o && ea_o == $past(oploc_i)))
        else $error("immediate mode misbehaved"); // R1

    AST_ZP_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (r_q.mode inside {M_ZP, M_ZPX, M_ZPY})) |->
        (ea_o[ADDR_W-1:DATA_W] == '0))
        else $error("zero-page result left page zero"); // R2

    AST_PTR_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && r_q.step != '0 && (r_q.mode inside {M_INDX, M_INDY})) |->
        (mem_addr_o[ADDR_W-1:DATA_W] == '0))
        else $error("pointer read left page zero"); // R4 R5

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o)
        else $error("read strobe longer than one cycle"); // R7

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o)
        else $error("read issued while idle"); // R7

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(r_q.mode) && $stable(r_q.loc)))
        else $error("latched operands changed mid-operation"); // R8

    AST_ERR_ZERO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (ea_o == '0))
        else $error("error completion with nonzero address"); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o)
        else $error("busy during done cycle"); // R10

endmodule

// File: tb/tb_ea_sequencer.sv
`timescale 1ns/1ps
module tb_ea_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [15:0] oploc_i = '0;
    logic [7:0]  x_i = '0;
    logic [7:0]  y_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_data_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] ea_o;
    logic        err_o;

    always #4 clk = ~clk;

    ea_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .oploc_i(oploc_i), .x_i(x_i), .y_i(y_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_data_i(mem_data_i),
        .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o), .err_o(err_o)
    );

    // sparse memory: planted bytes, otherwise a pattern from the address
    logic [7:0] planted [int];
    function automatic logic [7:0] mrd(input logic [15:0] a);
        if (planted.exists(int'(a))) return planted[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) mem_data_i <= mem_rd_o ? mrd(mem_addr_o) : 8'h00;

    typedef struct {
        logic [15:0] ea;
        logic        err;
        int          nrd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0, cyc = 0, start_cyc = 0, rd_cnt = 0, done_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model(input logic [3:0] m, input logic [15:0] loc,
                         input logic [7:0] x, input logic [7:0] y,
                         output logic [15:0] ea, output logic err, output int n);
        logic [7:0]  p;
        logic [15:0] p16;
        err = 1'b0;
        case (m)
            4'd0: begin ea = loc; n = 0; end
            4'd1: begin ea = {8'h00, mrd(loc)}; n = 1; end
            4'd2: begin p = mrd(loc) + x; ea = {8'h00, p}; n = 1; end
            4'd3: begin p = mrd(loc) + y; ea = {8'h00, p}; n = 1; end
            4'd4: begin ea = {mrd(loc + 16'd1), mrd(loc)}; n = 2; end
            4'd5: begin ea = {mrd(loc + 16'd1), mrd(loc)} + {8'h00, x}; n = 2; end
            4'd6: begin ea = {mrd(loc + 16'd1), mrd(loc)} + {8'h00, y}; n = 2; end
            4'd7: begin
                p  = mrd(loc) + x;
                ea = {mrd({8'h00, p + 8'd1}), mrd({8'h00, p})};
                n  = 3;
            end
            4'd8: begin
                p  = mrd(loc);
                ea = {mrd({8'h00, p + 8'd1}), mrd({8'h00, p})} + {8'h00, y};
                n  = 3;
            end
            4'd9: begin
                p16 = {mrd(loc + 16'd1), mrd(loc)};
                ea  = {mrd({p16[15:8], p16[7:0] + 8'd1}), mrd(p16)};
                n   = 4;
            end
            default: begin ea = 16'h0000; err = 1'b1; n = 0; end
        endcase
    endtask

    // monitor: pop the scoreboard on every completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_o) rd_cnt++;
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(ea_o == e.ea, e.tag, "ea", ea_o, e.ea);
                    chk(err_o == e.err, e.tag, "err", err_o, e.err);
                    chk(rd_cnt == e.nrd, {e.tag, "/R7"}, "read count", rd_cnt, e.nrd);
                    chk(cyc - start_cyc == 2 * e.nrd + 1, {e.tag, "/R7"}, "latency",
                        cyc - start_cyc, 2 * e.nrd + 1);
                    chk(!busy_o, "R10", "busy in done cycle", busy_o, 0);
                end
                rd_cnt = 0;
                done_cnt++;
            end
        end
    end

    // driver: push expectation, pulse start, optionally disturb, wait for done
    task automatic run_op(input logic [3:0] m, input logic [15:0] loc,
                          input logic [7:0] x, input logic [7:0] y,
                          input string tag, input bit disturb);
        exp_t e;
        int   target;
        model(m, loc, x, y, e.ea, e.err, e.nrd);
        e.tag  = tag;
        sb.push_back(e);
        target = done_cnt + 1;
        mode_i = m; oploc_i = loc; x_i = x; y_i = y;
        start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (e.nrd > 0)
            chk(busy_o, "R10", "busy after start", busy_o, 1);
        if (disturb && busy_o) begin
            mode_i = 4'd9; oploc_i = 16'hBEEF; x_i = 8'h33; y_i = 8'h44;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            mode_i = 4'd0; oploc_i = 16'h0BAD;
        end
        wait (done_cnt == target);
        @(negedge clk);
    endtask

    initial begin
        // planted corner bytes
        planted[16'h0200] = 8'h80;
        planted[16'h0300] = 8'h34; planted[16'h0301] = 8'h12;
        planted[16'h0310] = 8'hF0; planted[16'h0311] = 8'hFF;
        planted[16'h0320] = 8'hF0;
        planted[16'h00FF] = 8'h78; planted[16'h0000] = 8'h56;
        planted[16'h0330] = 8'hFF;
        planted[16'h0340] = 8'hFF; planted[16'h0341] = 8'h12;
        planted[16'h12FF] = 8'hCD;
        planted[16'h1200] = 8'hAB; planted[16'h1300] = 8'hEF;
        planted[16'h0350] = 8'h80; planted[16'h0351] = 8'h12;
        planted[16'h1280] = 8'h11; planted[16'h1281] = 8'h22;
        planted[16'hFFFF] = 8'h9A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_rd_o && !err_o && ea_o == 16'h0,
            "R10", "reset state", {busy_o, done_o, mem_rd_o, err_o}, 0);

        run_op(4'd0, 16'h1234, 8'h00, 8'h00, "R1", 1'b0);
        run_op(4'd0, 16'hFFFF, 8'h11, 8'h22, "R1", 1'b0);
        run_op(4'd1, 16'h0200, 8'h00, 8'h00, "R2", 1'b0);
        run_op(4'd2, 16'h0200, 8'h90, 8'h00, "R2", 1'b0);   // wraps to 0x0010
        run_op(4'd3, 16'h0200, 8'h00, 8'h05, "R2", 1'b0);
        run_op(4'd4, 16'h0300, 8'h00, 8'h00, "R3", 1'b0);   // 0x1234
        run_op(4'd5, 16'h0300, 8'hFF, 8'h00, "R3", 1'b0);   // page carry
        run_op(4'd6, 16'h0310, 8'h00, 8'h20, "R3", 1'b0);   // wraps to 0x0010
        run_op(4'd4, 16'hFFFF, 8'h00, 8'h00, "R3", 1'b0);   // high byte at 0x0000
        run_op(4'd7, 16'h0320, 8'h0F, 8'h00, "R4", 1'b0);   // pointer 0xFF
        run_op(4'd7, 16'h0200, 8'h10, 8'h00, "R4", 1'b0);
        run_op(4'd8, 16'h0330, 8'h00, 8'hC0, "R5", 1'b0);   // pointer 0xFF
        run_op(4'd9, 16'h0340, 8'h00, 8'h00, "R6", 1'b0);   // same-page high byte
        run_op(4'd9, 16'h0350, 8'h00, 8'h00, "R6", 1'b0);
        run_op(4'd10, 16'h0300, 8'h00, 8'h00, "R9", 1'b0);
        run_op(4'd15, 16'h4321, 8'h00, 8'h00, "R9", 1'b0);
        run_op(4'd5, 16'h0300, 8'h07, 8'h00, "R8", 1'b1);
        run_op(4'd8, 16'h0330, 8'h00, 8'h01, "R8", 1'b1);

        // literal spot checks of the model on the wrap corners
        begin
            logic [15:0] ea; logic er; int n;
            model(4'd9, 16'h0340, 8'h00, 8'h00, ea, er, n);
            chk(ea == 16'hABCD, "R6", "model page bug", ea, 16'hABCD);
            model(4'd2, 16'h0200, 8'h90, 8'h00, ea, er, n);
            chk(ea == 16'h0010, "R2", "model zp wrap", ea, 16'h0010);
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R8", "pending expectations", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule